// File: doc/BRIEF.md
# Bus-Master DMA Control Registers

This block is the host-facing register set of a single-channel bus-master DMA controller that serves a disk interface. A host reaches it through a small byte-addressed register port. The port holds a command byte, a status byte and a 32-bit base address for the descriptor table. The block does not fetch descriptors or move data. It issues start and stop pulses to a separate descriptor-walking engine, hands that engine a reloaded table pointer and a transfer direction, and learns about the engine's progress from busy, done and error inputs.

Start and stop are edge-driven. Only a change of the start bit in a command write has any effect. A stop request never cuts a transfer short: the block keeps reporting activity until the engine finishes. The drive interrupt is latched into the status byte on its rising edge and is passed on to the interrupt output.

Top module: `bmdma_regs`

## Requirements
- R1: A write to the command byte (offset 0) keeps only bit 0 (start) and bit 3 (direction). Every other bit reads back as zero.
- R2: A command write that leaves the start bit at its current value produces no start or stop pulse and does not change the pointer or the active bit. The stored command byte is still updated.
- R3: A command write that takes the start bit from 0 to 1 loads the table base into the engine pointer. If the active bit is clear, the write also sets the active bit and gives a one-cycle `eng_start` pulse. If the active bit is already set, there is no pulse.
- R4: A command write that takes the start bit from 1 to 0 gives a one-cycle `eng_stop` pulse. If `eng_busy` is low, the active bit clears. Otherwise the active bit stays set until `eng_done`. An `eng_done` always clears the active bit.
- R5: The table base occupies offsets 4 to 7. `reg_size` selects 1 byte (0), 2 bytes (1) or 4 bytes (2 or 3). A write changes only the addressed bytes, and bits 1:0 of the stored base are always zero.
- R6: A read returns its data on `reg_rdata` one cycle after `reg_rd` and holds it until the next read. A read at offsets 4 to 7 returns the base shifted right by 8 times (offset-4), masked to the access size.
- R7: A rising `irq_in` sets status bit 2 and drives `irq_out` high one cycle later. A falling `irq_in` takes `irq_out` low one cycle later and leaves bit 2 set.
- R8: A synchronous reset clears the command byte, the status byte, the table base, the engine pointer and both pulse outputs.
- R9: `eng_dir` reflects command bit 3, where 1 means the device writes into memory.
- R10: The status byte is at offset 2, with bit 0 active, bit 1 error and bit 2 interrupt. Writing 1 clears bits 1 and 2, and bit 0 ignores host writes. `eng_done` with `eng_err` high sets bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Byte offset |
| reg_size | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| reg_wdata | input | 32 | Write data, least significant byte at the offset |
| reg_rdata | output | 32 | Registered read data |
| eng_busy | input | 1 | Engine has a transfer in flight |
| eng_done | input | 1 | Engine finished its transfer |
| eng_err | input | 1 | Qualifies eng_done as failed |
| eng_start | output | 1 | One-cycle start request |
| eng_stop | output | 1 | One-cycle stop request |
| eng_ptr | output | 32 | Descriptor table pointer for the engine |
| eng_dir | output | 1 | 1: device writes memory |
| irq_in | input | 1 | Drive interrupt |
| irq_out | output | 1 | Interrupt to host |

## Verification
The assertions check the following on every cycle: a start pulse comes only together with a set start bit and a pointer equal to the prior base, the active bit is held while the engine is busy, a completion clears the active bit, an interrupt rise sets the latched bit, the pointer stays aligned, and read data is held between reads. The byte-lane merging of the base, the read shifting, the command masking and the clear-on-one status writes need exact values. Only the bench's directed scenarios can show those. The same applies to a restart while the block is still active, which reloads the pointer without a pulse, and to a reset in the middle of a transfer.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int CMD_BIT_GO  = 0;
  localparam int CMD_BIT_DIR = 3;
  localparam logic [7:0] CMD_KEEP = 8'h09;
  localparam int ST_ACT = 0;
  localparam int ST_ERR = 1;
  localparam int ST_INT = 2;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd2;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    lane_mask = {{(DATA_W-8){1'b0}}, 8'hFF};
      2'd1:    lane_mask = {{(DATA_W-16){1'b0}}, 16'hFFFF};
      default: lane_mask = {DATA_W{1'b1}};
    endcase
  endfunction
endpackage

// File: rtl/bmdma_base_reg.sv
module bmdma_base_reg
  import bmdma_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_off,
  input  logic [1:0]    wr_size,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_off,
  input  logic [1:0]    rd_size,
  output logic [DW-1:0] base_q,
  output logic [DW-1:0] rd_val
);
  localparam int SH_W = $clog2(DW);

  logic [SH_W-1:0] wr_sh, rd_sh;
  logic [DW-1:0]   wmask, wshift, merged;

  assign wr_sh  = SH_W'({wr_off, 3'b000});
  assign rd_sh  = SH_W'({rd_off, 3'b000});
  assign wmask  = lane_mask(wr_size) << wr_sh;
  assign wshift = wr_data << wr_sh;

  always_comb begin
    merged      = (base_q & ~wmask) | (wshift & wmask);
    merged[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst)        base_q <= '0;
    else if (wr_en) base_q <= merged;
  end

  assign rd_val = (base_q >> rd_sh) & lane_mask(rd_size);

  AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (base_q[1:0] == 2'b00));  // R5
endmodule

// File: rtl/bmdma_cmd_ctl.sv
module bmdma_cmd_ctl
  import bmdma_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic [7:0]    cmd_wdata,
  input  logic [DW-1:0] base,
  input  logic          eng_busy,
  input  logic          eng_done,
  output logic [7:0]    cmd_q,
  output logic          active,
  output logic          eng_start,
  output logic          eng_stop,
  output logic [DW-1:0] ptr
);
  logic go_on, go_off;

  assign go_on  = cmd_wr &  cmd_wdata[CMD_BIT_GO] & ~cmd_q[CMD_BIT_GO];
  assign go_off = cmd_wr & ~cmd_wdata[CMD_BIT_GO] &  cmd_q[CMD_BIT_GO];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      active    <= 1'b0;
      eng_start <= 1'b0;
      eng_stop  <= 1'b0;
      ptr       <= '0;
    end else begin
      eng_start <= 1'b0;
      eng_stop  <= 1'b0;
      if (cmd_wr) cmd_q <= cmd_wdata & CMD_KEEP;
      if (go_on) begin
        ptr <= base;
        if (!active) begin
          active    <= 1'b1;
          eng_start <= 1'b1;
        end
      end else if (go_off) begin
        eng_stop <= 1'b1;
        if (!eng_busy) active <= 1'b0;
      end
      if (eng_done && active) active <= 1'b0;
    end
  end

  AST_START_WITH_GO: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> (cmd_q[CMD_BIT_GO] && active));  // R3
  AST_START_PTR_LOADED: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_start) |-> (ptr == $past(base)));  // R3
  AST_NO_PULSE_SAME_GO: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (cmd_wdata[CMD_BIT_GO] == cmd_q[CMD_BIT_GO])) |=> (!eng_start && !eng_stop));  // R2
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (active && eng_busy && !eng_done) |=> active);  // R4
  AST_DONE_DROPS_ACT: assert property (@(posedge clk) disable iff (rst)
    (active && eng_done) |=> !active);  // R4
endmodule

// File: rtl/bmdma_stat_irq.sv
module bmdma_stat_irq
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stat_wr,
  input  logic [2:1] stat_w1c,
  input  logic       eng_done,
  input  logic       eng_err,
  input  logic       active,
  input  logic       irq_in,
  output logic       irq_out,
  output logic [7:0] stat_byte
);
  logic err_q, int_q, irq_rise;

  assign irq_rise = irq_in & ~irq_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= 1'b0;
      int_q   <= 1'b0;
      irq_out <= 1'b0;
    end else begin
      irq_out <= irq_in;
      if (eng_done && eng_err)       err_q <= 1'b1;
      else if (stat_wr && stat_w1c[ST_ERR]) err_q <= 1'b0;
      if (irq_rise)                  int_q <= 1'b1;
      else if (stat_wr && stat_w1c[ST_INT]) int_q <= 1'b0;
    end
  end

  always_comb begin
    stat_byte         = '0;
    stat_byte[ST_ACT] = active;
    stat_byte[ST_ERR] = err_q;
    stat_byte[ST_INT] = int_q;
  end

  AST_IRQ_RISE_LATCH: assert property (@(posedge clk) disable iff (rst)
    (irq_in && !irq_out) |=> (irq_out && int_q));  // R7
  AST_ERR_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
    (eng_done && eng_err) |=> err_q);  // R10
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [1:0]          reg_size,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                eng_busy,
  input  logic                eng_done,
  input  logic                eng_err,
  output logic                eng_start,
  output logic                eng_stop,
  output logic [DATA_W-1:0]   eng_ptr,
  output logic                eng_dir,
  input  logic                irq_in,
  output logic                irq_out
);
  logic              cmd_wr, stat_wr, base_wr, active;
  logic [7:0]        cmd_q, stat_byte;
  logic [DATA_W-1:0] base_q, base_rd;

  assign cmd_wr  = reg_wr && (reg_addr == OFF_CMD);
  assign stat_wr = reg_wr && (reg_addr == OFF_STAT);
  assign base_wr = reg_wr && reg_addr[2];

  bmdma_base_reg #(.DW(DATA_W)) u_base (
    .clk(clk), .rst(rst), .wr_en(base_wr), .wr_off(reg_addr[1:0]),
    .wr_size(reg_size), .wr_data(reg_wdata), .rd_off(reg_addr[1:0]),
    .rd_size(reg_size), .base_q(base_q), .rd_val(base_rd)
  );

  bmdma_cmd_ctl #(.DW(DATA_W)) u_cmd (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(reg_wdata[7:0]),
    .base(base_q), .eng_busy(eng_busy), .eng_done(eng_done),
    .cmd_q(cmd_q), .active(active), .eng_start(eng_start),
    .eng_stop(eng_stop), .ptr(eng_ptr)
  );

  bmdma_stat_irq u_stat (
    .clk(clk), .rst(rst), .stat_wr(stat_wr), .stat_w1c(reg_wdata[2:1]),
    .eng_done(eng_done), .eng_err(eng_err), .active(active),
    .irq_in(irq_in), .irq_out(irq_out), .stat_byte(stat_byte)
  );

  assign eng_dir = cmd_q[CMD_BIT_DIR];

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (reg_addr[2])              reg_rdata <= base_rd;
      else if (reg_addr == OFF_CMD)  reg_rdata <= {{(DATA_W-8){1'b0}}, cmd_q};
      else if (reg_addr == OFF_STAT) reg_rdata <= {{(DATA_W-8){1'b0}}, stat_byte};
      else                           reg_rdata <= '0;
    end
  end

  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    eng_ptr[1:0] == 2'b00);  // R5
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));  // R6
endmodule

// File: tb/bmdma_regs_bench.sv
`timescale 1ns/1ps
module bmdma_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [1:0]  reg_size = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_busy = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
  logic        eng_start, eng_stop, eng_dir, irq_in = 1'b0, irq_out;
  logic [31:0] eng_ptr;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  bmdma_regs u_bmdma_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .eng_busy(eng_busy), .eng_done(eng_done),
    .eng_err(eng_err), .eng_start(eng_start), .eng_stop(eng_stop),
    .eng_ptr(eng_ptr), .eng_dir(eng_dir), .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_size = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a; reg_size = s;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_done(input logic err);
    @(negedge clk);
    eng_done = 1'b1; eng_err = err;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, 2'd2, v); chk("R8 cmd after reset", v, 32'h0);
    rd(3'd2, 2'd0, v); chk("R8 status after reset", v, 32'h0);
    chk("R8 ptr after reset", eng_ptr, 32'h0);
    chk("R8 pulses after reset", {eng_start, eng_stop, irq_out}, 32'h0);
  endtask

  task automatic t_base();
    logic [31:0] v;
    wr(3'd4, 2'd2, 32'h1234_5677);
    rd(3'd4, 2'd2, v); chk("R5 word write low bits forced", v, 32'h1234_5674);
    wr(3'd5, 2'd0, 32'h0000_00AB);
    rd(3'd4, 2'd2, v); chk("R5 byte write lane 1", v, 32'h1234_AB74);
    wr(3'd6, 2'd1, 32'h0000_CDEF);
    rd(3'd4, 2'd2, v); chk("R5 half write upper", v, 32'hCDEF_AB74);
    wr(3'd4, 2'd0, 32'h0000_00FF);
    rd(3'd4, 2'd2, v); chk("R5 byte write lane 0", v, 32'hCDEF_ABFC);
    rd(3'd5, 2'd1, v); chk("R6 half read offset 5", v, 32'h0000_EFAB);
    rd(3'd7, 2'd0, v); chk("R6 byte read offset 7", v, 32'h0000_00CD);
    @(negedge clk); chk("R6 rdata held", reg_rdata, 32'h0000_00CD);
  endtask

  task automatic t_start();
    logic [31:0] v;
    wr(3'd0, 2'd0, 32'h0000_00FF);
    chk("R3 start pulse", eng_start, 1);
    chk("R3 ptr loaded", eng_ptr, 32'hCDEF_ABFC);
    chk("R9 dir write", eng_dir, 1);
    rd(3'd0, 2'd0, v); chk("R1 cmd masked", v, 32'h09);
    chk("R3 pulse single cycle", eng_start, 0);
    rd(3'd2, 2'd0, v); chk("R10 active set", v, 32'h01);
  endtask

  task automatic t_no_change();
    logic [31:0] v;
    wr(3'd4, 2'd2, 32'h0000_1000);
    wr(3'd0, 2'd0, 32'h0000_0001);
    chk("R2 no pulse on same start", {eng_start, eng_stop}, 0);
    chk("R2 ptr unchanged", eng_ptr, 32'hCDEF_ABFC);
    chk("R9 dir read", eng_dir, 0);
    rd(3'd0, 2'd0, v); chk("R2 cmd still stored", v, 32'h01);
    rd(3'd2, 2'd0, v); chk("R2 active unchanged", v, 32'h01);
  endtask

  task automatic t_stop_busy();
    logic [31:0] v;
    eng_busy = 1'b1;
    wr(3'd0, 2'd0, 32'h0);
    chk("R4 stop pulse", eng_stop, 1);
    repeat (3) @(negedge clk);
    rd(3'd2, 2'd0, v); chk("R4 active held while busy", v, 32'h01);
    wr(3'd0, 2'd0, 32'h1);
    chk("R3 no pulse when active", eng_start, 0);
    chk("R3 ptr reloaded when active", eng_ptr, 32'h0000_1000);
    pulse_done(1'b0);
    eng_busy = 1'b0;
    rd(3'd2, 2'd0, v); chk("R4 done clears active", v, 32'h00);
  endtask

  task automatic t_stop_idle();
    logic [31:0] v;
    wr(3'd0, 2'd0, 32'h0);
    wr(3'd0, 2'd0, 32'h1);
    chk("R3 restart pulse", eng_start, 1);
    wr(3'd0, 2'd0, 32'h0);
    rd(3'd2, 2'd0, v); chk("R4 idle stop clears", v, 32'h00);
  endtask

  task automatic t_status();
    logic [31:0] v;
    wr(3'd0, 2'd0, 32'h1);
    pulse_done(1'b1);
    rd(3'd2, 2'd0, v); chk("R10 error set", v, 32'h02);
    wr(3'd0, 2'd0, 32'h0);
    wr(3'd0, 2'd0, 32'h1);
    rd(3'd2, 2'd0, v); chk("R10 active and error", v, 32'h03);
    wr(3'd2, 2'd0, 32'h07);
    rd(3'd2, 2'd0, v); chk("R10 w1c keeps active", v, 32'h01);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    @(negedge clk); irq_in = 1'b1;
    @(negedge clk); chk("R7 irq out rises", irq_out, 1);
    rd(3'd2, 2'd0, v); chk("R7 int latched", v, 32'h05);
    @(negedge clk); irq_in = 1'b0;
    @(negedge clk); chk("R7 irq out falls", irq_out, 0);
    rd(3'd2, 2'd0, v); chk("R7 int stays", v, 32'h05);
    wr(3'd2, 2'd0, 32'h04);
    rd(3'd2, 2'd0, v); chk("R10 int cleared", v, 32'h01);
  endtask

  task automatic t_mid_reset();
    logic [31:0] v;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(3'd2, 2'd0, v); chk("R8 status cleared", v, 32'h0);
    rd(3'd0, 2'd0, v); chk("R8 cmd cleared", v, 32'h0);
    rd(3'd4, 2'd2, v); chk("R8 base cleared", v, 32'h0);
    chk("R8 ptr cleared", eng_ptr, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_base();
    t_start();
    t_no_change();
    t_stop_busy();
    t_stop_idle();
    t_status();
    t_irq();
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule